// File: doc/BRIEF.md
# Prefetch Candidate Filter and Issue Queue

This block sits between a stride predictor and the memory port of a data cache. It receives predicted prefetch addresses, reduces each to a cache-line address, and holds the newest one in a single-entry test slot. It checks that slot against the cache tags only in cycles the processor has announced, one cycle ahead, as free of loads and stores. A candidate whose line is already resident is thrown away. A candidate that misses moves into a small first-in first-out request queue.

The queue drains toward memory only when the memory port is ready and no demand miss is using it, so demand traffic always comes first. Each prefetch sent to memory also raises an allocate strobe carrying the same line. The prefetch cache uses that strobe to reserve a slot that is marked present but not yet filled. A candidate whose line is already held in the test slot or the request queue is dropped at entry, so the same line is never issued twice in a row.

Top module: `pf_filter_queue`

## Requirements
- R1: The line address driven on `probe_line` is the candidate address shifted right by log2(LINE_BYTES). With the defaults (AW=16, LINE_BYTES=16) it is `cand_addr[15:4]`.
- R2: `probe_valid` is high only in a cycle directly after a cycle in which `idle_next` was high. While it stays low, the test slot keeps its candidate.
- R3: A probe answered with `probe_hit` high in the same cycle is discarded, and its line is never sent to memory.
- R4: A probe answered with `probe_hit` low puts its line into the request queue. Queued lines are sent to memory in the order they entered.
- R5: `mem_req_valid` is high only in a cycle where `mem_ready` is high and `demand_req` is low. A queued line waits for as long as a demand miss holds the port.
- R6: `alloc_valid` is high in exactly the cycles where `mem_req_valid` is high, and `alloc_line` equals `mem_req_line`.
- R7: A new candidate that arrives while the test slot still holds an unprobed one overwrites it. Only the newest candidate is probed.
- R8: A probe that misses while the request queue is full and not draining in that cycle is dropped. The test slot is freed anyway.
- R9: A candidate whose line equals a line held in the request queue or the test slot is discarded on arrival. No line is sent to memory in two consecutive cycles.
- R10: While `rst_n` is low, and in the first cycle after it, `probe_valid`, `mem_req_valid` and `alloc_valid` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cand_valid | input | 1 | A predicted prefetch address is offered this cycle |
| cand_addr | input | AW | Predicted byte address |
| idle_next | input | 1 | The processor will issue no load/store in the next cycle |
| probe_valid | output | 1 | Tag probe to the data cache this cycle |
| probe_line | output | AW-log2(LINE_BYTES) | Line address being probed |
| probe_hit | input | 1 | Same-cycle tag probe result: line is resident |
| mem_ready | input | 1 | Memory port can accept a request |
| demand_req | input | 1 | A demand miss holds the memory port this cycle |
| mem_req_valid | output | 1 | Prefetch request issued to memory this cycle |
| mem_req_line | output | AW-log2(LINE_BYTES) | Line address of the issued prefetch |
| alloc_valid | output | 1 | Reserve a present-but-not-filled slot in the prefetch cache |
| alloc_line | output | AW-log2(LINE_BYTES) | Line address to reserve |

## Verification
The assertions assume the cache answers `probe_hit` in the same cycle as `probe_valid`. They also assume `demand_req` and `mem_ready` are settled before the clock edge. The bench stub drives the hit from a fixed resident line, decoded combinationally from `probe_line`, and changes every input only just after a falling edge. The no-repeat rule and the issue-versus-miss count rely on the duplicate filter at entry. For that reason the stimulus re-offers lines that are queued, lines being probed, and lines already issued, and does not feed any line to the block by another path.

// File: rtl/pf_pkg.sv
package pf_pkg;

   // What happens to the test-slot entry in the cycle it is probed
   typedef enum logic [1:0] {
      PO_NONE      = 2'd0,
      PO_HIT_DROP  = 2'd1,
      PO_QUEUE     = 2'd2,
      PO_FULL_DROP = 2'd3
   } probe_outcome_e;

endpackage

// File: rtl/pf_test_slot.sv
module pf_test_slot #(
   parameter int LW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [LW-1:0] load_line,
   input  logic          consume,
   output logic          slot_v,
   output logic [LW-1:0] slot_line
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slot_v    <= 1'b0;
         slot_line <= '0;
      end else if (load) begin
         slot_v    <= 1'b1;
         slot_line <= load_line;
      end else if (consume) begin
         slot_v    <= 1'b0;
      end
   end

endmodule

// File: rtl/pf_req_fifo.sv
module pf_req_fifo #(
   parameter int DEPTH = 2,
   parameter int LW    = 12
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      push,
   input  logic [LW-1:0]             push_line,
   input  logic                      pop,
   output logic                      empty,
   output logic                      full,
   output logic [LW-1:0]             head_line,
   output logic [DEPTH-1:0]          ent_v,
   output logic [DEPTH-1:0][LW-1:0]  ent_line
);

   generate
      if (DEPTH == 1) begin : g_single
         logic          v_q;
         logic [LW-1:0] l_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               v_q <= 1'b0;
               l_q <= '0;
            end else if (push) begin
               v_q <= 1'b1;
               l_q <= push_line;
            end else if (pop) begin
               v_q <= 1'b0;
            end
         end
         assign ent_v[0]    = v_q;
         assign ent_line[0] = l_q;
         assign head_line   = l_q;
      end else begin : g_ring
         localparam int PW = $clog2(DEPTH);
         logic [PW-1:0]          rd_q, wr_q;
         logic [DEPTH-1:0]       v_q;
         logic [DEPTH-1:0][LW-1:0] l_q;

         function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
            return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
         endfunction

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               rd_q <= '0;
               wr_q <= '0;
               v_q  <= '0;
               l_q  <= '0;
            end else begin
               if (pop) begin
                  v_q[rd_q] <= 1'b0;
                  rd_q      <= bump(rd_q);
               end
               if (push) begin
                  v_q[wr_q] <= 1'b1;
                  l_q[wr_q] <= push_line;
                  wr_q      <= bump(wr_q);
               end
            end
         end
         assign ent_v     = v_q;
         assign ent_line  = l_q;
         assign head_line = l_q[rd_q];
      end
   endgenerate

   assign empty = ~|ent_v;
   assign full  = &ent_v;

endmodule

// File: rtl/pf_line_match.sv
module pf_line_match #(
   parameter int N  = 2,
   parameter int LW = 12
) (
   input  logic [LW-1:0]         key,
   input  logic [N-1:0]          ent_v,
   input  logic [N-1:0][LW-1:0]  ent_line,
   output logic                  hit
);

   logic [N-1:0] eq;

   generate
      for (genvar i = 0; i < N; i++) begin : g_cmp
         assign eq[i] = ent_v[i] && (ent_line[i] == key);
      end
   endgenerate

   assign hit = |eq;

endmodule

// File: rtl/pf_filter_queue.sv
module pf_filter_queue #(
   parameter int AW         = 16,
   parameter int LINE_BYTES = 16,
   parameter int RQ_DEPTH   = 2,
   localparam int OFFW      = $clog2(LINE_BYTES),
   localparam int LAW       = AW - OFFW
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cand_valid,
   input  logic [AW-1:0]  cand_addr,
   input  logic           idle_next,
   output logic           probe_valid,
   output logic [LAW-1:0] probe_line,
   input  logic           probe_hit,
   input  logic           mem_ready,
   input  logic           demand_req,
   output logic           mem_req_valid,
   output logic [LAW-1:0] mem_req_line,
   output logic           alloc_valid,
   output logic [LAW-1:0] alloc_line
);
   import pf_pkg::*;

   generate
      if (LINE_BYTES < 2 || (LINE_BYTES & (LINE_BYTES - 1)) != 0) begin : g_bad_line
         $error("LINE_BYTES must be a power of two of at least 2");
      end
      if (RQ_DEPTH < 1) begin : g_bad_depth
         $error("RQ_DEPTH must be at least 1");
      end
      if (AW <= OFFW) begin : g_bad_aw
         $error("AW must exceed the line offset width");
      end
   endgenerate

   logic                          idle_q;
   logic [LAW-1:0]                cand_line;
   logic                          unused_offset;
   logic                          slot_v;
   logic [LAW-1:0]                slot_line;
   logic                          probe_fire;
   logic                          issue;
   logic                          rq_empty, rq_full;
   logic [LAW-1:0]                rq_head;
   logic [RQ_DEPTH-1:0]           rq_v;
   logic [RQ_DEPTH-1:0][LAW-1:0]  rq_line;
   logic                          in_queue;
   logic                          dup;
   logic                          cand_load;
   logic                          push;
   probe_outcome_e                outcome;

   assign cand_line     = cand_addr[AW-1:OFFW];
   assign unused_offset = ^cand_addr[OFFW-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) idle_q <= 1'b0;
      else        idle_q <= idle_next;
   end

   pf_line_match #(.N(RQ_DEPTH), .LW(LAW)) u_match (
      .key      (cand_line),
      .ent_v    (rq_v),
      .ent_line (rq_line),
      .hit      (in_queue)
   );

   assign dup       = in_queue || (slot_v && (slot_line == cand_line));
   assign cand_load = cand_valid && !dup;

   assign probe_fire = slot_v && idle_q;
   assign issue      = !rq_empty && mem_ready && !demand_req;

   always_comb begin
      outcome = PO_NONE;
      if (probe_fire) begin
         if (probe_hit)                outcome = PO_HIT_DROP;
         else if (!rq_full || issue)   outcome = PO_QUEUE;
         else                          outcome = PO_FULL_DROP;
      end
   end

   assign push = (outcome == PO_QUEUE);

   pf_test_slot #(.LW(LAW)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (cand_load),
      .load_line (cand_line),
      .consume   (probe_fire),
      .slot_v    (slot_v),
      .slot_line (slot_line)
   );

   pf_req_fifo #(.DEPTH(RQ_DEPTH), .LW(LAW)) u_rq (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push),
      .push_line (slot_line),
      .pop       (issue),
      .empty     (rq_empty),
      .full      (rq_full),
      .head_line (rq_head),
      .ent_v     (rq_v),
      .ent_line  (rq_line)
   );

   assign probe_valid   = probe_fire;
   assign probe_line    = slot_line;
   assign mem_req_valid = issue;
   assign mem_req_line  = rq_head;
   assign alloc_valid   = issue;
   assign alloc_line    = rq_head;

endmodule

// File: rtl/pf_filter_queue_chk.sv
module pf_filter_queue_chk #(
   parameter int LAW = 12
) (
   input logic           clk,
   input logic           rst_n,
   input logic           idle_next,
   input logic           probe_valid,
   input logic [LAW-1:0] probe_line,
   input logic           probe_hit,
   input logic           mem_ready,
   input logic           demand_req,
   input logic           mem_req_valid,
   input logic [LAW-1:0] mem_req_line,
   input logic           alloc_valid
);

   logic [31:0] n_miss, n_issue;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         n_miss  <= '0;
         n_issue <= '0;
      end else begin
         n_miss  <= n_miss  + 32'(probe_valid && !probe_hit);
         n_issue <= n_issue + 32'(mem_req_valid);
      end
   end

   a_r2_probe_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
      probe_valid |-> $past(idle_next));

   a_r5_demand_first: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> (mem_ready && !demand_req));

   a_r6_alloc_on_free_port: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_valid |-> (mem_ready && !demand_req));

   a_r3_hit_not_issued: assert property (@(posedge clk) disable iff (!rst_n)
      (probe_valid && probe_hit) |=> !(mem_req_valid && mem_req_line == $past(probe_line)));

   a_r4_issue_backed_by_miss: assert property (@(posedge clk) disable iff (!rst_n)
      n_issue <= n_miss);

   a_r9_no_back_to_back_repeat: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && $past(mem_req_valid)) |-> (mem_req_line != $past(mem_req_line)));

endmodule

bind pf_filter_queue pf_filter_queue_chk #(.LAW(LAW)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .idle_next     (idle_next),
   .probe_valid   (probe_valid),
   .probe_line    (probe_line),
   .probe_hit     (probe_hit),
   .mem_ready     (mem_ready),
   .demand_req    (demand_req),
   .mem_req_valid (mem_req_valid),
   .mem_req_line  (mem_req_line),
   .alloc_valid   (alloc_valid)
);

// File: tb/pf_filter_queue_bench.sv
module pf_filter_queue_bench;

   localparam int AW  = 16;
   localparam int LAW = 12;
   localparam logic [LAW-1:0] RESIDENT = 12'h0AA;

   logic           clk = 1'b0;
   logic           rst_n;
   logic           cand_valid;
   logic [AW-1:0]  cand_addr;
   logic           idle_next;
   logic           probe_valid;
   logic [LAW-1:0] probe_line;
   logic           probe_hit;
   logic           mem_ready;
   logic           demand_req;
   logic           mem_req_valid;
   logic [LAW-1:0] mem_req_line;
   logic           alloc_valid;
   logic [LAW-1:0] alloc_line;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 0;

   always #10 clk = ~clk;

   // cache tag stub: one resident line
   assign probe_hit = probe_valid && (probe_line == RESIDENT);

   pf_filter_queue u_pf_filter_queue (
      .clk(clk), .rst_n(rst_n), .cand_valid(cand_valid), .cand_addr(cand_addr),
      .idle_next(idle_next), .probe_valid(probe_valid), .probe_line(probe_line),
      .probe_hit(probe_hit), .mem_ready(mem_ready), .demand_req(demand_req),
      .mem_req_valid(mem_req_valid), .mem_req_line(mem_req_line),
      .alloc_valid(alloc_valid), .alloc_line(alloc_line)
   );

   // {cv, addr, idle, rdy, dem, exp_probe, exp_pline, exp_mem, exp_mline}
   localparam int VW = 46;
   localparam logic [VW-1:0] TBL [0:10] = '{
      {1'b1,16'h1234,1'b1,1'b0,1'b0, 1'b0,12'h000, 1'b0,12'h000},
      {1'b0,16'h0000,1'b0,1'b0,1'b0, 1'b1,12'h123, 1'b0,12'h000},
      {1'b0,16'h0000,1'b0,1'b1,1'b0, 1'b0,12'h000, 1'b1,12'h123},
      {1'b1,16'h0AA5,1'b1,1'b0,1'b0, 1'b0,12'h000, 1'b0,12'h000},
      {1'b0,16'h0000,1'b0,1'b0,1'b0, 1'b1,12'h0AA, 1'b0,12'h000},
      {1'b0,16'h0000,1'b0,1'b1,1'b0, 1'b0,12'h000, 1'b0,12'h000},
      {1'b1,16'h2000,1'b0,1'b0,1'b0, 1'b0,12'h000, 1'b0,12'h000},
      {1'b1,16'h3010,1'b1,1'b0,1'b0, 1'b0,12'h000, 1'b0,12'h000},
      {1'b0,16'h0000,1'b0,1'b0,1'b0, 1'b1,12'h301, 1'b0,12'h000},
      {1'b0,16'h0000,1'b0,1'b1,1'b0, 1'b0,12'h000, 1'b1,12'h301},
      {1'b0,16'h0000,1'b0,1'b1,1'b0, 1'b0,12'h000, 1'b0,12'h000}
   };

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   // drive one cycle's inputs just after the falling edge; outputs settle at +2
   task automatic step(input logic cv, input logic [AW-1:0] a, input logic idl,
                       input logic rdy, input logic dem);
      @(negedge clk);
      cand_valid = cv; cand_addr = a; idle_next = idl; mem_ready = rdy; demand_req = dem;
      #2;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      rst_n = 1'b0;
      cand_valid = 1'b1; cand_addr = 16'h5550; idle_next = 1'b1;
      mem_ready = 1'b1; demand_req = 1'b0;
      repeat (3) @(posedge clk);
      #2;
      chk("R10 probe in reset", 32'(probe_valid), 0);
      chk("R10 mem in reset", 32'(mem_req_valid), 0);
      chk("R10 alloc in reset", 32'(alloc_valid), 0);
      @(negedge clk);
      rst_n = 1'b1;
      cand_valid = 1'b0; idle_next = 1'b0; mem_ready = 1'b0;
      #2;
      chk("R10 probe after reset", 32'(probe_valid), 0);
      chk("R10 mem after reset", 32'(mem_req_valid), 0);

      // table: R1 alignment, R2 idle gating, R3 hit drop, R4 queue, R7 newest wins
      for (int i = 0; i < 11; i++) begin
         logic [VW-1:0] v;
         v = TBL[i];
         step(v[45], v[44:29], v[28], v[27], v[26]);
         chk($sformatf("R1/R2/R3/R4/R7 row %0d probe_valid", i), 32'(probe_valid), 32'(v[25]));
         if (v[25]) chk($sformatf("R1/R7 row %0d probe_line", i), 32'(probe_line), 32'(v[24:13]));
         chk($sformatf("R3/R4/R7 row %0d mem_req_valid", i), 32'(mem_req_valid), 32'(v[12]));
         if (v[12]) chk($sformatf("R4/R7 row %0d mem_req_line", i), 32'(mem_req_line), 32'(v[11:0]));
      end

      // R8 full queue drop, R5 demand priority, R6 allocate, R4 order
      step(1'b1, 16'h4000, 1'b1, 1'b0, 1'b0);
      step(1'b1, 16'h4100, 1'b1, 1'b0, 1'b0);
      chk("R4 probe 400", 32'(probe_line), 32'h400);
      step(1'b1, 16'h4200, 1'b1, 1'b0, 1'b0);
      chk("R4 probe 410", 32'(probe_line), 32'h410);
      step(1'b0, 16'h0000, 1'b0, 1'b0, 1'b0);
      chk("R8 probe while full", 32'(probe_valid), 1);
      step(1'b0, 16'h0000, 1'b0, 1'b1, 1'b1);
      chk("R5 held by demand", 32'(mem_req_valid), 0);
      chk("R6 no alloc under demand", 32'(alloc_valid), 0);
      step(1'b0, 16'h0000, 1'b0, 1'b1, 1'b0);
      chk("R5 issue after demand", 32'(mem_req_valid), 1);
      chk("R4 first in order", 32'(mem_req_line), 32'h400);
      chk("R6 alloc valid", 32'(alloc_valid), 1);
      chk("R6 alloc line", 32'(alloc_line), 32'h400);
      step(1'b0, 16'h0000, 1'b0, 1'b1, 1'b0);
      chk("R4 second in order", 32'(mem_req_line), 32'h410);
      step(1'b0, 16'h0000, 1'b0, 1'b1, 1'b0);
      chk("R8 dropped line not issued", 32'(mem_req_valid), 0);
      chk("R8 slot freed", 32'(probe_valid), 0);

      // R2 slot held while not idle, then R9 duplicate filter
      step(1'b1, 16'h6000, 1'b0, 1'b0, 1'b0);
      step(1'b0, 16'h0000, 1'b0, 1'b0, 1'b0);
      chk("R2 no probe when busy a", 32'(probe_valid), 0);
      step(1'b0, 16'h0000, 1'b1, 1'b0, 1'b0);
      chk("R2 no probe when busy b", 32'(probe_valid), 0);
      step(1'b0, 16'h0000, 1'b0, 1'b0, 1'b0);
      chk("R2 held candidate probed", 32'(probe_valid), 1);
      chk("R2 held candidate line", 32'(probe_line), 32'h600);
      step(1'b1, 16'h6004, 1'b1, 1'b0, 1'b0);
      step(1'b0, 16'h0000, 1'b0, 1'b0, 1'b0);
      chk("R9 duplicate not probed", 32'(probe_valid), 0);
      step(1'b0, 16'h0000, 1'b0, 1'b1, 1'b0);
      chk("R9 queued line issued", 32'(mem_req_line), 32'h600);
      step(1'b0, 16'h0000, 1'b0, 1'b1, 1'b0);
      chk("R9 issued once", 32'(mem_req_valid), 0);

      finish_run();
   end

endmodule